// File: doc/BRIEF.md
# Filtered Shift-Register Keystream Generator

This block generates a keystream one bit per clock from a 48-bit shift register that is read by a nonlinear filter. The filter is built from three small truth-table functions. Four-input functions sample groups of register taps, and a five-input function combines their results into the filter bit. A start pulse loads the register from the serial number and the low key bits. A 32-clock setup phase then runs. In it, the filter bit, one IV bit and one upper key bit are folded into the bit that enters the register.

After setup the block enters its run phase. There the filter bit is the keystream bit, and the register advances by linear feedback on every clock in which the enable input is high. During setup the block also collects the 32 filter bits XORed with the IV, which gives the masked IV that a receiver needs. The host XORs the keystream with its data outside this block.

Top module: `sc_stream_core`

## Requirements
- R1: After reset, ready_o=1, ks_valid_o=0, ks_bit_o=0 and enc_iv_o=0, and without a start pulse this holds whatever enable_i does.
- R2: A clock edge with start_i=1 begins setup. ready_o is 0 for exactly the 32 clocks that follow. After them, ready_o=1 and ks_valid_o=1 hold together until the next start.
- R3: At load the state bit s[n] takes serial_i[n] for n=0..31 and key_i[n-32] for n=32..47. Each clock shifts the state toward bit 0, and the new bit enters s[47].
- R4: Filter. A 4-bit index is built from a tap group, with its first-listed tap as the LSB. The groups are (1,2,4,5), (8,12,14,15), (17,21,23,26), (28,29,31,33) and (34,43,44,46). Groups 0 and 4 look up bit index of 0x2C79, and groups 1 to 3 look up bit index of 0x6671. Group g's result is bit g of a 5-bit index, and the filter bit is that bit of 0x7907287B.
- R5: In setup clock i (i=0..31), the bit entering s[47] is filter XOR iv[i] XOR key[16+i]. enc_iv_o[i] becomes filter XOR iv[i]. enc_iv_o then stays constant until the next start.
- R6: In the run phase, ks_bit_o shows the filter bit of the current state, and ks_bit_o is 0 whenever ks_valid_o=0. On an edge with enable_i=1, the bit entering s[47] is the XOR of taps 0,2,3,6,7,8,16,22,23,26,30,41,42,43,46 and 47.
- R7: In the run phase, an edge with enable_i=0 leaves the state unchanged. ks_bit_o holds, and the sequence resumes where it stopped.
- R8: Setup advances on every clock whatever enable_i is.
- R9: key_i, serial_i and iv_i are sampled only on the start edge, so changing them during setup or run has no effect.
- R10: A start pulse during setup or run abandons the current sequence and restarts from the new inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load inputs and begin setup |
| key_i | input | 48 | Secret key |
| serial_i | input | 32 | Serial number |
| iv_i | input | 32 | Initialization vector |
| enable_i | input | 1 | Advance keystream in the run phase |
| ks_bit_o | output | 1 | Current keystream bit |
| ks_valid_o | output | 1 | Run phase active, ks_bit_o valid |
| ready_o | output | 1 | Low during setup |
| enc_iv_o | output | 32 | IV masked with the setup filter bits |

## Verification
The generator is swept over twenty arithmetically spread key, serial and IV triples, plus the all-zero and all-one corners. The all-zero and all-one cases separate errors in the load mapping from errors in the filter tables. For each triple, the masked IV and 64 keystream bits are compared with a bench model. A periodic enable pattern stalls the run phase, which separates a true hold from a lost or repeated bit. Toggling the inputs during setup, toggling enable during setup, and restarting mid-setup and mid-run show that inputs are latched and that a start always wins.

// File: rtl/sc_cipher_pkg.sv
package sc_cipher_pkg;
  localparam int unsigned STATE_W   = 48;
  localparam int unsigned ID_W      = 32;
  localparam int unsigned KEY_W     = 48;
  localparam int unsigned IV_W      = 32;
  localparam int unsigned LO_KEY_W  = STATE_W - ID_W;
  localparam int unsigned HI_KEY_W  = KEY_W - LO_KEY_W;
  localparam int unsigned SETUP_CYC = IV_W;
  localparam int unsigned CNT_W     = $clog2(SETUP_CYC);

  localparam int unsigned N_SUB = 5;
  localparam int unsigned SUB_W = 4;
  localparam logic [(1<<SUB_W)-1:0] FA_TT = 16'h2C79;
  localparam logic [(1<<SUB_W)-1:0] FB_TT = 16'h6671;
  localparam logic [(1<<N_SUB)-1:0] FC_TT = 32'h7907287B;
  localparam logic [N_SUB-1:0] SUB_USES_FA = 5'b10001;
  // tap j of group g at index g*SUB_W+j, j=0 is index LSB
  localparam int unsigned SUB_TAP [N_SUB*SUB_W] = '{
    1, 2, 4, 5,   8, 12, 14, 15,   17, 21, 23, 26,
    28, 29, 31, 33,   34, 43, 44, 46};
  localparam logic [STATE_W-1:0] RUN_FB_MASK = 48'hCE00_44C1_01CD;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_RUN} phase_e;
endpackage

// File: rtl/sc_filter.sv
module sc_filter
  import sc_cipher_pkg::*;
(
  input  logic [STATE_W-1:0] state_i,
  output logic               fc_o
);
  logic [N_SUB-1:0] sub;

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    logic [SUB_W-1:0] idx;
    for (genvar j = 0; j < SUB_W; j++) begin : g_tap
      assign idx[j] = state_i[SUB_TAP[g*SUB_W+j]];
    end
    if (SUB_USES_FA[g]) begin : g_fa
      assign sub[g] = FA_TT[idx];
    end else begin : g_fb
      assign sub[g] = FB_TT[idx];
    end
  end

  assign fc_o = FC_TT[sub];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_cipher_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic setup_o,
  output logic run_o
);
  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_SETUP;
      cnt_q   <= '0;
    end else if (phase_q == PH_SETUP) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == CNT_W'(SETUP_CYC - 1)) phase_q <= PH_RUN;
    end
  end

  assign setup_o = (phase_q == PH_SETUP);
  assign run_o   = (phase_q == PH_RUN);
endmodule

// File: rtl/sc_datapath.sv
module sc_datapath
  import sc_cipher_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                setup_i,
  input  logic                adv_i,
  input  logic [KEY_W-1:0]    key_i,
  input  logic [ID_W-1:0]     serial_i,
  input  logic [IV_W-1:0]     iv_i,
  output logic                fc_o,
  output logic [IV_W-1:0]     enc_iv_o
);
  logic [STATE_W-1:0]  st_q;
  logic [HI_KEY_W-1:0] khi_q;
  logic [IV_W-1:0]     ivx_q;   // holds IV, shifted out as masked IV fills in
  logic                fc, setup_fb, run_fb;

  sc_filter i_filter (.state_i(st_q), .fc_o(fc));

  assign setup_fb = fc ^ ivx_q[0] ^ khi_q[0];
  assign run_fb   = ^(st_q & RUN_FB_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      khi_q <= '0;
      ivx_q <= '0;
    end else if (load_i) begin
      st_q  <= {key_i[LO_KEY_W-1:0], serial_i};
      khi_q <= key_i[KEY_W-1:LO_KEY_W];
      ivx_q <= iv_i;
    end else if (setup_i) begin
      st_q  <= {setup_fb, st_q[STATE_W-1:1]};
      khi_q <= {1'b0, khi_q[HI_KEY_W-1:1]};
      ivx_q <= {fc ^ ivx_q[0], ivx_q[IV_W-1:1]};
    end else if (adv_i) begin
      st_q  <= {run_fb, st_q[STATE_W-1:1]};
    end
  end

  assign fc_o     = fc;
  assign enc_iv_o = ivx_q;
endmodule

// File: rtl/sc_stream_core.sv
module sc_stream_core
  import sc_cipher_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [ID_W-1:0]  serial_i,
  input  logic [IV_W-1:0]  iv_i,
  input  logic             enable_i,
  output logic             ks_bit_o,
  output logic             ks_valid_o,
  output logic             ready_o,
  output logic [IV_W-1:0]  enc_iv_o
);
  logic setup, run, fc;

  sc_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .setup_o (setup),
    .run_o   (run)
  );

  sc_datapath i_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start_i),
    .setup_i  (setup),
    .adv_i    (run & enable_i),
    .key_i    (key_i),
    .serial_i (serial_i),
    .iv_i     (iv_i),
    .fc_o     (fc),
    .enc_iv_o (enc_iv_o)
  );

  assign ks_bit_o   = run & fc;
  assign ks_valid_o = run;
  assign ready_o    = ~setup;
endmodule

// File: rtl/sc_stream_core_chk.sv
module sc_stream_core_chk
  import sc_cipher_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [KEY_W-1:0] key_i,
  input logic [ID_W-1:0]  serial_i,
  input logic [IV_W-1:0]  iv_i,
  input logic             enable_i,
  input logic             ks_bit_o,
  input logic             ks_valid_o,
  input logic             ready_o,
  input logic [IV_W-1:0]  enc_iv_o
);
  logic [7:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          low_cnt_q <= '0;
    else if (start_i)                     low_cnt_q <= '0;
    else if (!ready_o && low_cnt_q != 8'hFF) low_cnt_q <= low_cnt_q + 1'b1;
  end

  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !ks_valid_o && !start_i |=> ready_o && !ks_valid_o); // R1
  AST_START_DROPS_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !ready_o && !ks_valid_o); // R10
  AST_SETUP_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> low_cnt_q == 8'(SETUP_CYC) && ks_valid_o); // R2
  AST_VALID_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o |-> ready_o); // R2
  AST_BIT_ZERO_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ks_valid_o |-> !ks_bit_o); // R6
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o && !enable_i && !start_i |=> ks_valid_o && $stable(ks_bit_o)); // R7
  AST_ENC_IV_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ks_valid_o && !start_i |=> $stable(enc_iv_o)); // R5
  AST_SETUP_NO_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o && !start_i && low_cnt_q < 8'(SETUP_CYC - 1) |=> !ready_o); // R8
endmodule

bind sc_stream_core sc_stream_core_chk i_chk (.*);

// File: tb/test_sc_stream_core.sv
module test_sc_stream_core;
  logic        clk_i = 0, rst_ni = 0, start_i = 0, enable_i = 0;
  logic [47:0] key_i = '0;
  logic [31:0] serial_i = '0, iv_i = '0;
  logic        ks_bit_o, ks_valid_o, ready_o;
  logic [31:0] enc_iv_o;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  sc_stream_core i_sc_stream_core (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_filter(input logic [47:0] s);
    int unsigned tp [20] = '{1,2,4,5, 8,12,14,15, 17,21,23,26, 28,29,31,33, 34,43,44,46};
    logic [4:0] i5;
    for (int g = 0; g < 5; g++) begin
      int idx = 0;
      for (int j = 0; j < 4; j++) idx += int'(s[tp[g*4+j]]) << j;
      i5[g] = (g == 0 || g == 4) ? ((16'h2C79 >> idx) & 1) : ((16'h6671 >> idx) & 1);
    end
    return (32'h7907287B >> i5) & 1;
  endfunction

  function automatic logic [47:0] m_run_next(input logic [47:0] s);
    logic b = s[0]^s[2]^s[3]^s[6]^s[7]^s[8]^s[16]^s[22]^s[23]^s[26]^s[30]^
              s[41]^s[42]^s[43]^s[46]^s[47];
    return {b, s[47:1]};
  endfunction

  // full start/setup/run sequence; wiggle=1 changes inputs after the start edge
  task automatic run_vec(input logic [47:0] k, input logic [31:0] sn, input logic [31:0] v,
                         input bit wiggle, input int nbits);
    logic [47:0] s = {k[15:0], sn};
    logic [31:0] enc;
    int low = 0;
    for (int i = 0; i < 32; i++) begin
      logic f = m_filter(s);
      enc[i] = f ^ v[i];
      s = {f ^ v[i] ^ k[16+i], s[47:1]};
    end
    @(negedge clk_i);
    key_i = k; serial_i = sn; iv_i = v; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    if (wiggle) begin key_i = ~k; serial_i = ~sn; iv_i = ~v; end  // R9
    for (int c = 0; c < 32; c++) begin
      if (!ready_o && !ks_valid_o) low++;
      enable_i = c[0];  // R8: enable irrelevant in setup
      @(negedge clk_i);
    end
    chk(low == 32, "R2 setup low cycles", 64'(low), 64'd32);
    chk(ready_o && ks_valid_o, "R2 ready/valid after setup", {ready_o, ks_valid_o}, 2'b11);
    chk(enc_iv_o == enc, wiggle ? "R9 R5 enc_iv latched" : "R5 enc_iv", enc_iv_o, enc);
    for (int n = 0; n < nbits; n++) begin
      bit en = (n % 5) != 3;
      chk(ks_valid_o && ks_bit_o == m_filter(s), en ? "R4 R6 keystream" : "R7 hold",
          ks_bit_o, m_filter(s));
      if (wiggle) begin key_i = k ^ 48'(n); iv_i = v + 32'(n); end
      enable_i = en;
      @(negedge clk_i);
      if (en) s = m_run_next(s);
    end
    chk(enc_iv_o == enc, "R5 enc_iv stable in run", enc_iv_o, enc);
    enable_i = 0;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(ready_o && !ks_valid_o && !ks_bit_o && enc_iv_o == 0, "R1 reset state",
        {ready_o, ks_valid_o, ks_bit_o, enc_iv_o}, {3'b100, 32'h0});
    for (int c = 0; c < 6; c++) begin
      enable_i = c[0];
      @(negedge clk_i);
    end
    chk(ready_o && !ks_valid_o && !ks_bit_o, "R1 idle ignores enable",
        {ready_o, ks_valid_o, ks_bit_o}, 3'b100);

    run_vec('0, '0, '0, 0, 64);                 // R3 all-zero corner
    run_vec('1, '1, '1, 0, 64);                 // R3 all-one corner
    run_vec(48'h4F4E_4D4C_4B4A, 32'h8765_4321, 32'h75B5_DE65, 0, 64);
    for (int v = 0; v < 20; v++) begin
      logic [47:0] k = {16'(v * 16'hA5C3) ^ 16'h1F2E, 32'(v + 1) * 32'h9E37_79B9};
      logic [31:0] sn = 32'h8765_4321 ^ (32'(v) * 32'h0100_0193);
      logic [31:0] iv = 32'h75B5_DE65 + 32'(v) * 32'h3C6E_F372;
      run_vec(k, sn, iv, v % 4 == 1, 64);       // mid-run restart each time (R10)
    end

    // R10: restart in the middle of setup
    @(negedge clk_i);
    key_i = 48'h1234_5678_9ABC; serial_i = 32'hDEAD_BEEF; iv_i = 32'h0BAD_F00D; start_i = 1;
    @(negedge clk_i);
    start_i = 0;
    repeat (10) @(negedge clk_i);
    chk(!ready_o, "R10 in setup before restart", ready_o, 1'b0);
    run_vec(48'hCAFE_0000_F00D, 32'h1357_9BDF, 32'h2468_ACE0, 0, 40);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule